// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block is a clocked monostable pulse generator. It watches two asynchronous trigger pins of opposite edge sense. One fires on a falling edge, gated by the other pin being high. The other fires on a rising edge, gated by the first pin being low. On a qualified trigger it drives a pulse of a programmable number of clock cycles on a pair of complementary outputs.

A trigger that arrives while the pulse is running starts the full width again, so the output stays high for one whole width after the last trigger that was taken. An active-low clear ends any pulse and then holds the block deaf to triggers for a fixed recovery time. A minimum spacing between accepted triggers stops two trigger edges that come close together from counting as two starts.

All pins pass through two synchroniser flops. Edges are found by comparing each synchronised sample with the one before it. All timing comes from synchronous down-counters.

Top module: `retrig_oneshot`

## Requirements
- R1: During and after reset, pulse_o is low and pulse_no is high. No recovery lockout is pending after reset, so the first qualified trigger is accepted.
- R2: A falling edge on fire_fall_i, while fire_rise_i is high and clear_ni is high, is a trigger. pulse_o rises on the third rising clock edge after the pin change.
- R3: A rising edge on fire_rise_i, while fire_fall_i is low and clear_ni is high, is a trigger. It has the same latency as R2.
- R4: Edges that do not meet the gating have no effect on the outputs. These are a fall on fire_fall_i with fire_rise_i low, a rise on fire_rise_i with fire_fall_i high, a rise on fire_fall_i, and a fall on fire_rise_i.
- R5: An accepted trigger holds pulse_o high for exactly width_i clock cycles. width_i is sampled only when the trigger is accepted, so later changes do not alter the running pulse.
- R6: A width_i value of zero gives a pulse of one clock cycle.
- R7: A trigger accepted while pulse_o is high reloads the count. pulse_o then stays high until one full sampled width after that trigger.
- R8: A trigger arriving fewer than MIN_GAP cycles after the previously accepted trigger is ignored. MIN_GAP defaults to 3.
- R9: clear_ni low drives pulse_o low three clock edges after the pin change. Clear overrides a trigger edge seen in the same cycle.
- R10: After the synchronised clear returns high, triggers are ignored for RECOV_CYC cycles (default 4). They are accepted from the next cycle on.
- R11: pulse_no is always the complement of pulse_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fire_fall_i | input | 1 | Trigger pin that is active on its falling edge (asynchronous) |
| fire_rise_i | input | 1 | Trigger pin that is active on its rising edge (asynchronous) |
| clear_ni | input | 1 | Active-low clear (asynchronous) |
| width_i | input | WIDTH_W | Pulse length in clock cycles; 0 means 1 |
| pulse_o | output | 1 | One-shot output |
| pulse_no | output | 1 | Complement of pulse_o, driven from its own flop |

## Verification
The properties take for granted that the only way pulse_o can rise is through a synchronised, qualified edge. They also assume that the synchronised clear is the sole source of the lockout. For this reason they are written against the synchroniser output, not the raw pins, and they accept any pattern of pin activity. The stimulus changes the pins only on the falling clock edge, so each change lands cleanly in the first synchroniser stage. This lets the bench's cycle model predict the exact edge at which the output moves. Random pin toggling, including clears at any time and widths of zero, stays inside that assumption.

// File: rtl/os_pkg.sv
package os_pkg;

  // Synchronised pin bundle; bit order is {clear_n, rise pin, fall pin}
  typedef struct packed {
    logic clr_n;
    logic b;
    logic a;
  } os_pins_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_LOCK  = 2'd2
  } os_state_e;

endpackage

// File: rtl/os_rst_sync.sv
module os_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_no = stg2_q;

endmodule

// File: rtl/os_sync2.sv
module os_sync2 #(
  parameter int unsigned  N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, safe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        safe_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        safe_q <= meta_q;
      end
    end

    assign q_o[i] = safe_q;
  end

endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
  import os_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  os_pins_t pins_i,
  output logic     trig_o
);

  logic prev_a_q, prev_b_q;
  logic prev_a_d, prev_b_d;
  logic fall_a, rise_b;

  always_comb begin
    fall_a   = prev_a_q & ~pins_i.a;
    rise_b   = ~prev_b_q & pins_i.b;
    trig_o   = pins_i.clr_n & ((fall_a & pins_i.b) | (rise_b & ~pins_i.a));
    prev_a_d = pins_i.a;
    prev_b_d = pins_i.b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b1;
    end else begin
      prev_a_q <= prev_a_d;
      prev_b_q <= prev_b_d;
    end
  end

endmodule

// File: rtl/os_timer.sv
module os_timer
  import os_pkg::*;
#(
  parameter int unsigned WIDTH_W   = 8,
  parameter int unsigned RECOV_CYC = 4,
  parameter int unsigned MIN_GAP   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_n_i,
  input  logic               trig_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               qn_o
);

  localparam int unsigned RCW = $clog2(RECOV_CYC + 1);
  localparam int unsigned GW  = $clog2(MIN_GAP + 1);
  localparam logic [RCW-1:0] REC_LOAD = RCW'(RECOV_CYC);
  localparam logic [GW-1:0]  GAP_LOAD = GW'(MIN_GAP - 1);

  os_state_e          state_q, state_d;
  logic [WIDTH_W-1:0] cnt_q, cnt_d, w_eff;
  logic [RCW-1:0]     rec_q, rec_d;
  logic [GW-1:0]      gap_q, gap_d;
  logic               q_q, qn_q, q_d;
  logic               gap_ok;

  always_comb begin
    w_eff   = (width_i == '0) ? WIDTH_W'(1) : width_i;
    gap_ok  = (gap_q == '0);
    state_d = state_q;
    cnt_d   = cnt_q;
    rec_d   = rec_q;
    gap_d   = gap_ok ? gap_q : gap_q - 1'b1;

    if (!clr_n_i) begin
      state_d = ST_LOCK;
      cnt_d   = '0;
      rec_d   = REC_LOAD;
      gap_d   = '0;
    end else begin
      unique case (state_q)
        ST_LOCK: begin
          if (rec_q <= RCW'(1)) begin
            state_d = ST_IDLE;
            rec_d   = '0;
          end else begin
            rec_d = rec_q - 1'b1;
          end
        end
        ST_IDLE: begin
          if (trig_i && gap_ok) begin
            state_d = ST_PULSE;
            cnt_d   = w_eff;
            gap_d   = GAP_LOAD;
          end
        end
        ST_PULSE: begin
          if (trig_i && gap_ok) begin
            cnt_d = w_eff;
            gap_d = GAP_LOAD;
          end else if (cnt_q == WIDTH_W'(1)) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    q_d = (state_d == ST_PULSE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      gap_q   <= '0;
      q_q     <= 1'b0;
      qn_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rec_q   <= rec_d;
      gap_q   <= gap_d;
      q_q     <= q_d;
      qn_q    <= ~q_d;
    end
  end

  assign q_o  = q_q;
  assign qn_o = qn_q;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import os_pkg::*;
#(
  parameter int unsigned WIDTH_W   = 8,
  parameter int unsigned RECOV_CYC = 4,
  parameter int unsigned MIN_GAP   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_fall_i,
  input  logic               fire_rise_i,
  input  logic               clear_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o,
  output logic               pulse_no
);

  logic     rst_int_n;
  logic     trig_vld;
  logic     q_w, qn_w;
  logic [2:0] s_vec;
  os_pins_t s_pins;

  os_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  os_sync2 #(
    .N       (3),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    ({clear_ni, fire_rise_i, fire_fall_i}),
    .q_o    (s_vec)
  );

  assign s_pins = os_pins_t'(s_vec);

  os_edge_qual u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .pins_i (s_pins),
    .trig_o (trig_vld)
  );

  os_timer #(
    .WIDTH_W   (WIDTH_W),
    .RECOV_CYC (RECOV_CYC),
    .MIN_GAP   (MIN_GAP)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .clr_n_i (s_pins.clr_n),
    .trig_i  (trig_vld),
    .width_i (width_i),
    .q_o     (q_w),
    .qn_o    (qn_w)
  );

  assign pulse_o  = q_w;
  assign pulse_no = qn_w;

endmodule

// File: rtl/os_chk.sv
module os_chk
  import os_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 4
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     pulse_o,
  input logic     pulse_no,
  input os_pins_t pins,
  input logic     trig_vld
);

  localparam int unsigned LKW = $clog2(RECOV_CYC + 1);

  logic [LKW-1:0] lk_q;

  // independent lockout tracker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lk_q <= '0;
    else if (!pins.clr_n)   lk_q <= LKW'(RECOV_CYC);
    else if (lk_q != '0)    lk_q <= lk_q - 1'b1;
  end

  p_compl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_no == !pulse_o);

  p_clear_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins.clr_n |=> !pulse_o);

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && !trig_vld) |=> !pulse_o);

  p_rise_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(trig_vld && pins.clr_n));

  p_lockout_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_q != '0 && !pulse_o) |=> !pulse_o);

endmodule

bind retrig_oneshot os_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pulse_o  (pulse_o),
  .pulse_no (pulse_no),
  .pins     (s_pins),
  .trig_vld (trig_vld)
);

// File: tb/sim_retrig_oneshot.sv
`timescale 1ns/1ps
module sim_retrig_oneshot;

  localparam int WW = 8;
  localparam int RC = 4;
  localparam int MG = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          a, b, clr_n;
  logic [WW-1:0] width;
  logic          pulse_o, pulse_no;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  retrig_oneshot #(.WIDTH_W(WW), .RECOV_CYC(RC), .MIN_GAP(MG)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .fire_fall_i (a),
    .fire_rise_i (b),
    .clear_ni    (clr_n),
    .width_i     (width),
    .pulse_o     (pulse_o),
    .pulse_no    (pulse_no)
  );

  // ---------------- reference model built from the requirements
  logic [2:0] ms1, ms2;
  logic mpa, mpb, mq;
  int   mcnt, mrec, mgap, rcnt;

  function automatic int eff_w(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic m_reset();
    ms1 = 3'b110; ms2 = 3'b110; mpa = 1'b0; mpb = 1'b1;
    mq = 1'b0; mcnt = 0; mrec = 0; mgap = 0;
  endtask

  always @(posedge clk) begin
    logic sa, sb, sc, trig, acc;
    if (!rst_ni) begin
      rcnt = 0; m_reset();
    end else if (rcnt < 2) begin
      rcnt++; m_reset();
    end else begin
      sa = ms2[0]; sb = ms2[1]; sc = ms2[2];
      trig = sc && ((mpa && !sa && sb) || (!mpb && sb && !sa));
      acc  = trig && mrec == 0 && mgap == 0;
      if (!sc) begin
        mq = 1'b0; mcnt = 0; mrec = RC; mgap = 0;
      end else begin
        if (mrec != 0) mrec--;
        if (acc) begin
          mq = 1'b1; mcnt = eff_w(int'(width)); mgap = MG - 1;
        end else begin
          if (mgap != 0) mgap--;
          if (mq) begin
            if (mcnt == 1) begin mq = 1'b0; mcnt = 0; end
            else mcnt--;
          end
        end
      end
      mpa = sa; mpb = sb; ms2 = ms1; ms1 = {clr_n, b, a};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(pulse_o === mq, cur_tag, int'(pulse_o), int'(mq));
      chk(pulse_no === !mq, "R11", int'(pulse_no), int'(!mq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; a = 1'b1; b = 1'b1; clr_n = 1'b1; width = 8'd4;
    cur_tag = "R1";
    cyc(5);
    rst_ni = 1'b1;
    cyc(3);
    // R1: no lockout after reset, first trigger accepted
    a = 1'b0; cyc(10); a = 1'b1; cyc(5);

    cur_tag = "R2";
    width = 8'd6; a = 1'b0; cyc(12); a = 1'b1; cyc(5);

    cur_tag = "R4";
    b = 1'b0; cyc(3); a = 1'b0; cyc(5);     // A fall with B low: ignored
    cur_tag = "R3";
    b = 1'b1; cyc(12);                      // B rise with A low
    cur_tag = "R4";
    a = 1'b1; cyc(3); b = 1'b0; cyc(3); b = 1'b1; cyc(5); // B rise with A high
    b = 1'b0; cyc(2); b = 1'b1; a = 1'b1; cyc(5);

    cur_tag = "R5";
    width = 8'd5; a = 1'b0; cyc(2); width = 8'd12; cyc(10);
    a = 1'b1; width = 8'd5; cyc(5);

    cur_tag = "R6";
    width = 8'd0; a = 1'b0; cyc(5); a = 1'b1; cyc(5);

    cur_tag = "R7";
    width = 8'd6; a = 1'b0; cyc(4); a = 1'b1; cyc(1); a = 1'b0; cyc(12);
    a = 1'b1; cyc(5);

    cur_tag = "R8";
    a = 1'b0; cyc(1); b = 1'b0; cyc(1); b = 1'b1; cyc(12);
    a = 1'b1; cyc(5);

    cur_tag = "R9";
    width = 8'd10; a = 1'b0; cyc(3); clr_n = 1'b0; cyc(3); a = 1'b1; cyc(3);
    clr_n = 1'b1; cyc(15);
    a = 1'b0; clr_n = 1'b0; cyc(4);        // trigger and clear together

    cur_tag = "R10";
    clr_n = 1'b1; cyc(1); a = 1'b1; cyc(1); a = 1'b0; cyc(1);
    a = 1'b1; cyc(1); a = 1'b0; cyc(15); a = 1'b1; cyc(5);

    cur_tag = "R7";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) a = ~a;
      if ($urandom % 4 == 0) b = ~b;
      clr_n = ($urandom % 60) != 0;
      if ($urandom % 8 == 0) width = WW'($urandom % 12);
      cyc(1);
    end
    clr_n = 1'b1; cyc(20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule